// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit does decimal arithmetic on one byte that holds two packed BCD digits. It offers three operations: add, subtract and negate. Add and subtract take a source byte, a destination byte and an incoming extend bit. Negate subtracts the source byte and the extend bit from zero. A start strobe captures the operands. The result byte and the updated flags are registered. They appear on the cycle after the strobe, together with a one-cycle done pulse.

The unit is meant to walk a long decimal number one byte at a time, starting with the least significant byte. The caller feeds the extend output back into the extend input between bytes, so the decimal carry or borrow moves up the string. The caller also feeds the zero output back into the zero input. The zero flag is then sticky and stays set at the end only if every result byte was zero.

Top module: `bcd_byte_unit`

## Requirements
- R1: After reset, resultOut, xOut, cOut, zOut and doneOut are all 0.
- R2: With opSel 0 (add), the result is dstByte + srcByte + xIn in decimal, modulo 100, as two packed BCD digits with the high digit in bits 7:4. The carry is 1 when the decimal sum is 100 or more.
- R3: With opSel 1 (subtract), the result is dstByte - srcByte - xIn in decimal. When that value is negative, 100 is added and the borrow is 1.
- R4: With opSel 2 or 3 (negate), the result is 0 - srcByte - xIn in decimal and dstByte has no effect. This gives the ten's complement when xIn is 0 and the nine's complement when xIn is 1. The borrow is 1 unless srcByte and xIn are both zero.
- R5: xOut and cOut both carry the carry of R2 or the borrow of R3 and R4.
- R6: zOut is 0 when the result byte is nonzero. Otherwise zOut equals the zIn presented with the start strobe.
- R7: The outputs update only on the clock edge that samples startIn high. doneOut is 1 for exactly the cycle after each such edge. Without start, the outputs hold their values.
- R8: The carry or borrow between digits follows decimal rules. For example, 09 + 01 gives 10 and 10 - 01 gives 09.
- R9: A multi-byte string processed from the low byte upward gives the correct decimal sum or difference of the whole numbers when xOut is fed back into xIn and zOut into zIn. The final zOut is 1 only if every result byte was zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Capture strobe for the operands and the operation |
| opSel | input | 2 | 0 add, 1 subtract, 2 or 3 negate |
| srcByte | input | 8 | Source operand, two packed BCD digits |
| dstByte | input | 8 | Destination operand, two packed BCD digits (ignored for negate) |
| xIn | input | 1 | Incoming extend bit (carry or borrow from the lower byte) |
| zIn | input | 1 | Incoming zero flag |
| resultOut | output | 8 | Registered packed BCD result |
| xOut | output | 1 | Updated extend bit |
| cOut | output | 1 | Updated carry bit, equal to xOut |
| zOut | output | 1 | Updated sticky zero flag |
| doneOut | output | 1 | Pulses for one cycle when the result is valid |

## Verification
Directed operands check the digit carry and borrow, both wrap-arounds past 99 and below 00, and the difference between the ten's and nine's complement in negate. A sweep over every pair of valid BCD bytes, with xIn alternating, compares all three operations against integer decimal arithmetic. The sweep separates carry from no carry at every digit boundary. The zero flag is tried with a zero result under both zIn values and with a nonzero result, which tells sticky behaviour apart from plain recomputation. Chained three-byte additions and subtractions check that the extend bit crosses byte borders.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_NEG  = 2'd2,
    OP_NEG2 = 2'd3
  } bcdOp_t;

  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell (
  input  logic [3:0] aDig,
  input  logic [3:0] bDig,
  input  logic       carryIn,
  input  logic       isSub,
  output logic [3:0] resDig,
  output logic       carryOut
);
  logic [4:0] rawAdd;
  logic [4:0] rawSub;

  always_comb begin
    rawAdd = {1'b0, aDig} + {1'b0, bDig} + {4'b0, carryIn};
    rawSub = {1'b0, aDig} - {1'b0, bDig} - {4'b0, carryIn};
    if (isSub) begin
      carryOut = rawSub[4];
      resDig   = rawSub[4] ? (rawSub[3:0] - 4'd6) : rawSub[3:0];
    end else begin
      carryOut = (rawAdd > 5'd9);
      resDig   = (rawAdd > 5'd9) ? (rawAdd[3:0] + 4'd6) : rawAdd[3:0];
    end
  end
endmodule

// File: rtl/bcd_control.sv
module bcd_control
  import bcd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  output ctrlStrobes_t ctrl,
  output logic         doneOut
);
  always_comb ctrl.capture = startIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneOut <= 1'b0;
    else       doneOut <= startIn;
  end
endmodule

// File: rtl/bcd_datapath.sv
module bcd_datapath
  import bcd_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t ctrl,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] srcByte,
  input  logic [W-1:0] dstByte,
  input  logic         xIn,
  input  logic         zIn,
  output logic [W-1:0] resultOut,
  output logic         xOut,
  output logic         cOut,
  output logic         zOut
);
  logic         isNeg;
  logic         isSub;
  logic [W-1:0] opA;
  logic [W-1:0] sumNext;
  logic [DIGITS:0] chain;

  always_comb begin
    isNeg = opSel[1];
    isSub = isNeg | (bcdOp_t'(opSel) == OP_SUB);
    opA   = isNeg ? '0 : dstByte;
  end

  assign chain[0] = xIn;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_cell u_cell (
      .aDig    (opA[4*d +: 4]),
      .bDig    (srcByte[4*d +: 4]),
      .carryIn (chain[d]),
      .isSub   (isSub),
      .resDig  (sumNext[4*d +: 4]),
      .carryOut(chain[d+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      xOut      <= 1'b0;
      cOut      <= 1'b0;
      zOut      <= 1'b0;
    end else if (ctrl.capture) begin
      resultOut <= sumNext;
      xOut      <= chain[DIGITS];
      cOut      <= chain[DIGITS];
      zOut      <= (sumNext == '0) ? zIn : 1'b0;
    end
  end
endmodule

// File: rtl/bcd_byte_unit.sv
module bcd_byte_unit
  import bcd_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] srcByte,
  input  logic [W-1:0] dstByte,
  input  logic         xIn,
  input  logic         zIn,
  output logic [W-1:0] resultOut,
  output logic         xOut,
  output logic         cOut,
  output logic         zOut,
  output logic         doneOut
);
  ctrlStrobes_t ctrl;

  bcd_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .ctrl   (ctrl),
    .doneOut(doneOut)
  );

  bcd_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opSel    (opSel),
    .srcByte  (srcByte),
    .dstByte  (dstByte),
    .xIn      (xIn),
    .zIn      (zIn),
    .resultOut(resultOut),
    .xOut     (xOut),
    .cOut     (cOut),
    .zOut     (zOut)
  );
endmodule

// File: rtl/bcd_byte_unit_chk.sv
module bcd_byte_unit_chk #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input logic         clk,
  input logic         rstN,
  input logic         startIn,
  input logic [1:0]   opSel,
  input logic [W-1:0] srcByte,
  input logic [W-1:0] dstByte,
  input logic         xIn,
  input logic         zIn,
  input logic [W-1:0] resultOut,
  input logic         xOut,
  input logic         cOut,
  input logic         zOut,
  input logic         doneOut
);
  function automatic logic isBcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_ADD_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && opSel == 2'd0 && isBcd(srcByte) && isBcd(dstByte)) |=> isBcd(resultOut)); // R2
  AST_SUB_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && opSel != 2'd0 && isBcd(srcByte) && isBcd(dstByte)) |=> isBcd(resultOut)); // R3
  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (xOut == cOut)); // R5
  AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !zIn) |=> !zOut); // R6
  AST_ZERO_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && resultOut != '0) |-> !zOut); // R6
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> doneOut); // R7
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(startIn)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> ($stable(resultOut) && $stable(xOut) && $stable(zOut))); // R7
endmodule

bind bcd_byte_unit bcd_byte_unit_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/sim_bcd_byte_unit.sv
module sim_bcd_byte_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [1:0] opSel = 2'd0;
  logic [7:0] srcByte = 8'h00;
  logic [7:0] dstByte = 8'h00;
  logic       xIn = 1'b0;
  logic       zIn = 1'b0;
  logic [7:0] resultOut;
  logic       xOut, cOut, zOut, doneOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcd_byte_unit u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opSel(opSel),
    .srcByte(srcByte), .dstByte(dstByte), .xIn(xIn), .zIn(zIn),
    .resultOut(resultOut), .xOut(xOut), .cOut(cOut), .zOut(zOut),
    .doneOut(doneOut)
  );

  function automatic int fromBcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(input int v);
    logic [7:0] r;
    r[7:4] = 4'((v / 10) % 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  // Model from R2, R3, R4, R5, R6: returns {result, carry, zero}
  function automatic logic [9:0] model(input logic [1:0] op, input logic [7:0] s,
                                       input logic [7:0] d, input logic x, input logic z);
    int v;
    logic c;
    logic [7:0] r;
    if (op == 2'd0) begin
      v = fromBcd(d) + fromBcd(s) + int'(x);
      c = (v >= 100);
      if (c) v = v - 100;
    end else begin
      v = ((op == 2'd1) ? fromBcd(d) : 0) - fromBcd(s) - int'(x);
      c = (v < 0);
      if (c) v = v + 100;
    end
    r = toBcd(v);
    return {r, c, (r == 8'h00) ? z : 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation, checks result, flags and done the cycle after start
  task automatic runOp(input string tag, input logic [1:0] op, input logic [7:0] s,
                       input logic [7:0] d, input logic x, input logic z);
    logic [9:0] e;
    e = model(op, s, d, x, z);
    opSel = op; srcByte = s; dstByte = d; xIn = x; zIn = z; startIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    check(tag, {resultOut, xOut, cOut, zOut, doneOut}, {e[9:2], e[1], e[1], e[0], 1'b1});
  endtask

  task automatic testReset;
    check("R1 reset state", {resultOut, xOut, cOut, zOut, doneOut}, 12'h000);
  endtask

  task automatic testAdd;
    runOp("R2 add 12+34", 2'd0, 8'h34, 8'h12, 1'b0, 1'b0);
    check("R2 add value", resultOut, 8'h46);
    runOp("R2 add 45+55 wrap", 2'd0, 8'h55, 8'h45, 1'b0, 1'b0);
    check("R5 add carry", {xOut, cOut}, 2'b11);
    runOp("R2 add 99+99+1", 2'd0, 8'h99, 8'h99, 1'b1, 1'b0);
    check("R2 add max", resultOut, 8'h99);
    runOp("R8 add digit carry", 2'd0, 8'h01, 8'h09, 1'b0, 1'b0);
    check("R8 09+01", resultOut, 8'h10);
  endtask

  task automatic testSub;
    runOp("R3 sub 46-12", 2'd1, 8'h12, 8'h46, 1'b0, 1'b0);
    check("R3 sub value", resultOut, 8'h34);
    runOp("R8 sub digit borrow", 2'd1, 8'h01, 8'h10, 1'b0, 1'b0);
    check("R8 10-01", resultOut, 8'h09);
    runOp("R3 sub 00-01", 2'd1, 8'h01, 8'h00, 1'b0, 1'b0);
    check("R3 underflow", {resultOut, cOut}, {8'h99, 1'b1});
    runOp("R3 sub 50-50-1", 2'd1, 8'h50, 8'h50, 1'b1, 1'b0);
    check("R5 sub borrow", {xOut, cOut}, 2'b11);
  endtask

  task automatic testNeg;
    runOp("R4 neg tens", 2'd2, 8'h25, 8'h00, 1'b0, 1'b0);
    check("R4 ten's complement", resultOut, 8'h75);
    runOp("R4 neg nines", 2'd2, 8'h25, 8'h00, 1'b1, 1'b0);
    check("R4 nine's complement", resultOut, 8'h74);
    runOp("R4 neg zero", 2'd2, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R4 neg of zero", {resultOut, cOut, zOut}, {8'h00, 1'b0, 1'b1});
    runOp("R4 neg dst ignored op3", 2'd3, 8'h25, 8'h77, 1'b0, 1'b0);
    check("R4 dst no effect", resultOut, 8'h75);
  endtask

  task automatic testZero;
    runOp("R6 zero kept", 2'd0, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R6 z stays 1", zOut, 1'b1);
    runOp("R6 zero not set", 2'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R6 z stays 0", zOut, 1'b0);
    runOp("R6 nonzero clears", 2'd0, 8'h01, 8'h00, 1'b0, 1'b1);
    check("R6 z cleared", zOut, 1'b0);
  endtask

  task automatic testTiming;
    logic [7:0] held;
    runOp("R7 op", 2'd0, 8'h21, 8'h13, 1'b0, 1'b0);
    held = resultOut;
    srcByte = 8'h55; dstByte = 8'h44; xIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 done single cycle", doneOut, 1'b0);
    check("R7 hold without start", {resultOut, xOut}, {held, 1'b0});
    runOp("R7 back to back a", 2'd1, 8'h11, 8'h22, 1'b0, 1'b0);
    runOp("R7 back to back b", 2'd0, 8'h11, 8'h22, 1'b0, 1'b0);
  endtask

  task automatic testChain(input string tag, input logic [1:0] op,
                           input logic [23:0] s, input logic [23:0] d,
                           input logic [23:0] expR, input logic expX, input logic expZ);
    logic x;
    logic z;
    logic [23:0] got;
    x = 1'b0; z = 1'b1;
    for (int k = 0; k < 3; k++) begin
      runOp(tag, op, s[8*k +: 8], d[8*k +: 8], x, z);
      got[8*k +: 8] = resultOut;
      x = xOut; z = zOut;
    end
    check(tag, {got, x, z}, {expR, expX, expZ});
  endtask

  task automatic testSweep;
    for (int i = 0; i < 100; i++) begin
      for (int j = 0; j < 100; j++) begin
        logic xs;
        xs = 1'((i + j) & 1);
        runOp("R2 sweep add", 2'd0, toBcd(j), toBcd(i), xs, 1'b1);
        runOp("R3 sweep sub", 2'd1, toBcd(j), toBcd(i), xs, 1'b1);
        runOp("R4 sweep neg", 2'd2, toBcd(j), toBcd(i), xs, 1'b1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAdd();
    testSub();
    testNeg();
    testZero();
    testTiming();
    testChain("R9 chain add", 2'd0, 24'h876544, 24'h123456, 24'h000000, 1'b1, 1'b1);
    testChain("R9 chain sub", 2'd1, 24'h000001, 24'h100000, 24'h099999, 1'b0, 1'b0);
    testChain("R9 chain neg", 2'd2, 24'h000001, 24'h000000, 24'h999999, 1'b1, 1'b0);
    testSweep();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule